// File: doc/BRIEF.md
# Prioritized Descriptor Schedule Scanner

The scanner decides which transfer descriptor an execution engine works on next. Descriptors sit in three tables of 32 slots each: isochronous, interrupt and asynchronous. Each slot has a valid flag and a skip flag. Only a slot that is valid and not skipped is eligible. Each asynchronous slot also carries link fields: a link enable, a terminate flag and a 5-bit pointer to another asynchronous slot.

A frame-start strobe starts a pass. The pass serves the isochronous class first, then the interrupt class, then the asynchronous class. Within a class, slots are taken in ascending index order. An executed asynchronous slot can redirect the scan to the slot named by its pointer, or end the pass through its terminate flag. The chosen class and slot are held at the outputs until the engine returns a done strobe.

The controller has three states:
- `ST_WAIT` is the idle state.
- `ST_SEARCH` looks for the next eligible slot in the current class at or above a cursor. It uses one cycle per class probe.
- `ST_HOLD` presents the selection to the engine.

The transitions are:
- `start` moves any state to `ST_SEARCH` at isochronous slot 0.
- `hit` goes from `ST_SEARCH` to `ST_HOLD`.
- `miss_next` stays in `ST_SEARCH` and moves to the next class at slot 0.
- `miss_end` goes from `ST_SEARCH` to `ST_WAIT` after an asynchronous miss.
- `advance` goes from `ST_HOLD` to `ST_SEARCH` on done.
- `finish` goes from `ST_HOLD` to `ST_WAIT` on done when the chain ends: the terminate flag is set, or the asynchronous slot 31 completes without a jump.

Top module: `sched_scanner`

## Requirements
- R1: After reset, `idle` is 1 and `sel_vld` is 0.
- R2: Within one pass, every isochronous selection comes before any interrupt selection, and every interrupt selection comes before any asynchronous selection. The class codes are 0 for isochronous, 1 for interrupt and 2 for asynchronous.
- R3: When no jump is taken, the slots of a class are selected in ascending index order. A completed slot 31 moves the scan to the next class.
- R4: A slot whose skip bit is 1 is never selected, even when its valid bit is 1.
- R5: A slot whose valid bit is 0 is never selected.
- R6: While `sel_vld` is 1, and neither `done` nor `frame_start` is 1, `sel_class` and `sel_slot` stay unchanged.
- R7: When an asynchronous slot with link enable 1 and terminate 0 completes, the scan continues at the slot given by its pointer (bits [5*i+4:5*i] of `async_link_ptr` for slot i). The scan searches upward from that slot, and the target may lie below the completed slot.
- R8: When an asynchronous slot with link enable 1 and terminate 1 completes, the pass ends and `idle` returns to 1.
- R9: The link fields of a slot that is never selected, including a valid slot that is skipped, have no effect on the selection order.
- R10: When no eligible slot remains, `idle` goes to 1. `idle` and `sel_vld` are never 1 together.
- R11: A `frame_start` strobe restarts the scan from isochronous slot 0. This holds even while a selection is being held, and it drops that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start-of-frame strobe, restarts the pass |
| done | input | 1 | Engine finished the held selection |
| iso_valid | input | 32 | Isochronous slot valid flags |
| int_valid | input | 32 | Interrupt slot valid flags |
| async_valid | input | 32 | Asynchronous slot valid flags |
| iso_skip | input | 32 | Isochronous slot skip flags |
| int_skip | input | 32 | Interrupt slot skip flags |
| async_skip | input | 32 | Asynchronous slot skip flags |
| async_link_en | input | 32 | Per asynchronous slot: take the pointer jump after execution |
| async_link_term | input | 32 | Per asynchronous slot: end the pass after execution when linked |
| async_link_ptr | input | 160 | Five-bit jump target per asynchronous slot, slot i at bits [5*i+4:5*i] |
| sel_vld | output | 1 | A selection is presented |
| sel_class | output | 2 | Selected class (0 isochronous, 1 interrupt, 2 asynchronous) |
| sel_slot | output | 5 | Selected slot index |
| idle | output | 1 | No eligible slot remains in this pass |

## Verification
The assertions rely on two conditions on the inputs:
- The flag tables and link fields stay constant while a pass is running. This lets the eligibility check on the held selection compare against current inputs.
- `done` is raised only while `sel_vld` is 1.

The stimulus meets both. It rewrites the tables only when `idle` is 1, and all `done` pulses come from the monitor, which acknowledges only a presented selection. The link chains are built so that each pass ends, either by a terminate flag or by running past slot 31.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        CLS_ISO   = 2'd0,
        CLS_INT   = 2'd1,
        CLS_ASYNC = 2'd2
    } sched_cls_e;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HOLD   = 2'd2
    } sched_state_e;
endpackage

// File: rtl/sched_first_find.sv
// Lowest set bit of an eligibility vector at or above a start index.
module sched_first_find #(
    parameter int SLOTS = 32,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] elig,
    input  logic [IDX_W-1:0] from_idx,
    output logic             found,
    output logic [IDX_W-1:0] hit_idx
);
    logic [SLOTS-1:0] masked;

    always_comb begin
        masked  = elig & ({SLOTS{1'b1}} << from_idx);
        found   = |masked;
        hit_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (masked[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/sched_advance.sv
// Cursor that follows the completion of the held slot.
module sched_advance
    import sched_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  sched_cls_e       cls,
    input  logic [IDX_W-1:0] slot,
    input  logic             link_en,
    input  logic             link_term,
    input  logic [IDX_W-1:0] link_ptr,
    output logic             stop,
    output sched_cls_e       nxt_cls,
    output logic [IDX_W-1:0] nxt_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    always_comb begin
        stop    = 1'b0;
        nxt_cls = cls;
        nxt_idx = slot + 1'b1;
        if (cls == CLS_ASYNC && link_en) begin
            stop    = link_term;
            nxt_idx = link_ptr;
        end else if (slot == LAST) begin
            nxt_idx = '0;
            unique case (cls)
                CLS_ISO:   nxt_cls = CLS_INT;
                CLS_INT:   nxt_cls = CLS_ASYNC;
                default:   stop    = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sched_scanner.sv
module sched_scanner
    import sched_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     done,
    input  logic [SLOTS-1:0]         iso_valid,
    input  logic [SLOTS-1:0]         int_valid,
    input  logic [SLOTS-1:0]         async_valid,
    input  logic [SLOTS-1:0]         iso_skip,
    input  logic [SLOTS-1:0]         int_skip,
    input  logic [SLOTS-1:0]         async_skip,
    input  logic [SLOTS-1:0]         async_link_en,
    input  logic [SLOTS-1:0]         async_link_term,
    input  logic [SLOTS*IDX_W-1:0]   async_link_ptr,
    output logic                     sel_vld,
    output logic [1:0]               sel_class,
    output logic [IDX_W-1:0]         sel_slot,
    output logic                     idle
);
    localparam int NCLS = 3;

    sched_state_e     state_q, state_d;
    sched_cls_e       cur_cls_q, cur_cls_d, sel_cls_q, sel_cls_d;
    logic [IDX_W-1:0] cur_idx_q, cur_idx_d, sel_slot_q, sel_slot_d;

    // eligibility per class: valid and not skipped
    logic [NCLS*SLOTS-1:0] valid_all, skip_all;
    logic [SLOTS-1:0]      elig [NCLS];
    assign valid_all = {async_valid, int_valid, iso_valid};
    assign skip_all  = {async_skip, int_skip, iso_skip};

    for (genvar c = 0; c < NCLS; c++) begin : g_elig
        assign elig[c] = valid_all[c*SLOTS +: SLOTS] & ~skip_all[c*SLOTS +: SLOTS];
    end

    logic [SLOTS-1:0] scan_vec, held_vec;
    always_comb begin
        unique case (cur_cls_q)
            CLS_ISO: scan_vec = elig[0];
            CLS_INT: scan_vec = elig[1];
            default: scan_vec = elig[2];
        endcase
        unique case (sel_cls_q)
            CLS_ISO: held_vec = iso_valid & ~iso_skip;
            CLS_INT: held_vec = int_valid & ~int_skip;
            default: held_vec = async_valid & ~async_skip;
        endcase
    end

    logic             f_found;
    logic [IDX_W-1:0] f_idx;

    sched_first_find #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_find (
        .elig     (scan_vec),
        .from_idx (cur_idx_q),
        .found    (f_found),
        .hit_idx  (f_idx)
    );

    logic             adv_stop;
    sched_cls_e       adv_cls;
    logic [IDX_W-1:0] adv_idx;

    sched_advance #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_adv (
        .cls       (sel_cls_q),
        .slot      (sel_slot_q),
        .link_en   (async_link_en[sel_slot_q]),
        .link_term (async_link_term[sel_slot_q]),
        .link_ptr  (async_link_ptr[sel_slot_q*IDX_W +: IDX_W]),
        .stop      (adv_stop),
        .nxt_cls   (adv_cls),
        .nxt_idx   (adv_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT;
            cur_cls_q  <= CLS_ISO;
            cur_idx_q  <= '0;
            sel_cls_q  <= CLS_ISO;
            sel_slot_q <= '0;
        end else begin
            state_q    <= state_d;
            cur_cls_q  <= cur_cls_d;
            cur_idx_q  <= cur_idx_d;
            sel_cls_q  <= sel_cls_d;
            sel_slot_q <= sel_slot_d;
        end
    end

    // transitions
    always_comb begin
        state_d    = state_q;
        cur_cls_d  = cur_cls_q;
        cur_idx_d  = cur_idx_q;
        sel_cls_d  = sel_cls_q;
        sel_slot_d = sel_slot_q;
        if (frame_start) begin
            state_d   = ST_SEARCH;
            cur_cls_d = CLS_ISO;
            cur_idx_d = '0;
        end else begin
            unique case (state_q)
                ST_WAIT: ;
                ST_SEARCH: begin
                    if (f_found) begin
                        sel_cls_d  = cur_cls_q;
                        sel_slot_d = f_idx;
                        state_d    = ST_HOLD;
                    end else if (cur_cls_q == CLS_ASYNC) begin
                        state_d = ST_WAIT;
                    end else begin
                        cur_cls_d = (cur_cls_q == CLS_ISO) ? CLS_INT : CLS_ASYNC;
                        cur_idx_d = '0;
                    end
                end
                ST_HOLD: begin
                    if (done) begin
                        if (adv_stop) begin
                            state_d = ST_WAIT;
                        end else begin
                            state_d   = ST_SEARCH;
                            cur_cls_d = adv_cls;
                            cur_idx_d = adv_idx;
                        end
                    end
                end
                default: state_d = ST_WAIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        sel_vld   = (state_q == ST_HOLD);
        idle      = (state_q == ST_WAIT);
        sel_class = sel_cls_q;
        sel_slot  = sel_slot_q;
    end

    // lowest class permitted for the next selection in this pass
    sched_cls_e cls_floor_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cls_floor_q <= CLS_ISO;
        else if (frame_start)      cls_floor_q <= CLS_ISO;
        else if (sel_vld && done)  cls_floor_q <= sel_cls_q;
    end

    assert_class_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> (sel_class >= cls_floor_q));

    // R5 also covered: held slot must be valid and unskipped
    assert_no_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> held_vec[sel_slot]);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && !done && !frame_start) |=> (sel_vld && $stable(sel_class) && $stable(sel_slot)));

    assert_term_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && done && !frame_start && sel_class == 2'd2
         && async_link_en[sel_slot] && async_link_term[sel_slot]) |=> idle);

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_vld && idle));

    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!idle && !sel_vld));
endmodule

// File: tb/sched_scanner_tb.sv
module sched_scanner_tb;
    localparam int SLOTS = 32;
    localparam int IW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic done = 1'b0;
    logic [SLOTS-1:0] tv [3];
    logic [SLOTS-1:0] ts [3];
    logic [SLOTS-1:0] l_en, l_term;
    logic [IW-1:0]    l_ptr [SLOTS];
    logic [SLOTS*IW-1:0] ptr_flat;
    logic sel_vld, idle;
    logic [1:0] sel_class;
    logic [IW-1:0] sel_slot;

    always #5 clk = ~clk;

    for (genvar i = 0; i < SLOTS; i++) begin : g_ptr
        assign ptr_flat[i*IW +: IW] = l_ptr[i];
    end

    sched_scanner u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .done(done),
        .iso_valid(tv[0]), .int_valid(tv[1]), .async_valid(tv[2]),
        .iso_skip(ts[0]), .int_skip(ts[1]), .async_skip(ts[2]),
        .async_link_en(l_en), .async_link_term(l_term), .async_link_ptr(ptr_flat),
        .sel_vld(sel_vld), .sel_class(sel_class), .sel_slot(sel_slot), .idle(idle)
    );

    int checks = 0;
    int failures = 0;
    string req = "R1";
    logic [6:0] exp_q [$];
    logic ack_en = 1'b0;
    logic man_ack = 1'b0;

    task automatic chk(input logic ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // expected order derived from the requirements
    task automatic model_push();
        logic ended = 1'b0;
        int guard = 0;
        for (int c = 0; c < 3 && !ended; c++) begin
            int idx = 0;
            while (idx < SLOTS && !ended && guard < 200) begin
                int hit = -1;
                for (int j = SLOTS - 1; j >= idx; j--)
                    if (tv[c][j] && !ts[c][j]) hit = j;
                if (hit < 0) break;
                exp_q.push_back({2'(c), 5'(hit)});
                guard++;
                if (c == 2 && l_en[hit]) begin
                    if (l_term[hit]) ended = 1'b1;
                    else idx = int'(l_ptr[hit]);
                end else begin
                    idx = hit + 1;
                end
            end
        end
    endtask

    // monitor: pops the scoreboard on each presented selection and acknowledges it
    initial begin
        forever begin
            @(negedge clk);
            done = 1'b0;
            if (man_ack) begin
                done = 1'b1;
                man_ack = 1'b0;
            end else if (ack_en && sel_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {req, " unexpected selection"}, {sel_class, sel_slot}, -1);
                end else begin
                    logic [6:0] e;
                    e = exp_q.pop_front();
                    chk({sel_class, sel_slot} == e, {req, " order"}, {sel_class, sel_slot}, e);
                end
                done = 1'b1;
            end
        end
    end

    task automatic pulse_start();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!(idle && exp_q.size() == 0) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(idle, {req, " R10 idle at end"}, idle, 1);
        chk(exp_q.size() == 0, {req, " R10 all expected seen"}, exp_q.size(), 0);
        @(negedge clk);
        chk(!sel_vld, {req, " R10 no selection when idle"}, sel_vld, 0);
    endtask

    task automatic wait_sel();
        int n = 0;
        while (!sel_vld && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_tables();
        for (int c = 0; c < 3; c++) begin
            tv[c] = '0;
            ts[c] = '0;
        end
        l_en = '0;
        l_term = '0;
        for (int i = 0; i < SLOTS; i++) l_ptr[i] = '0;
    endtask

    task automatic run_frame();
        model_push();
        ack_en = 1'b1;
        pulse_start();
        wait_idle();
        ack_en = 1'b0;
    endtask

    task automatic mixed_tables();
        clear_tables();
        tv[0] = (32'd1 << 3) | (32'd1 << 7);
        ts[0] = (32'd1 << 7);
        tv[1] = 32'h8000_0001;
        tv[2] = (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 9);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        checks++;
        $display("FAIL watchdog expired req=%s actual=0 expected=1", req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_tables();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(sel_vld == 1'b0, "R1 sel_vld", sel_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle == 1'b1 && !sel_vld, "R1 after release", idle, 1);

        // R2 R3 R4 R5: class priority, ascending order, skip overrides valid
        req = "R2_R3_R4_R5";
        mixed_tables();
        run_frame();

        // R7 R9: backward jump, skipped slot with a link
        req = "R7_R9";
        clear_tables();
        tv[2] = (32'd1 << 0) | (32'd1 << 2) | (32'd1 << 6) | (32'd1 << 9) | (32'd1 << 15);
        ts[2] = (32'd1 << 0);
        l_en[0] = 1'b1; l_ptr[0] = 5'd15;
        l_en[2] = 1'b1; l_ptr[2] = 5'd9;
        l_en[9] = 1'b1; l_ptr[9] = 5'd6;
        l_en[6] = 1'b1; l_term[6] = 1'b1;
        run_frame();

        // R8: forward jump then terminate
        req = "R8";
        clear_tables();
        tv[2] = (32'd1 << 1) | (32'd1 << 4) | (32'd1 << 10) | (32'd1 << 20) | (32'd1 << 25);
        l_en[4] = 1'b1; l_ptr[4] = 5'd20;
        l_en[20] = 1'b1; l_term[20] = 1'b1;
        tv[1] = 32'd1 << 31;
        run_frame();

        // R10: empty tables, and all valid but all skipped
        req = "R10";
        clear_tables();
        run_frame();
        for (int c = 0; c < 3; c++) begin
            tv[c] = '1;
            ts[c] = '1;
        end
        run_frame();

        // R3: all slots of the isochronous class, wrap at slot 31
        req = "R3";
        clear_tables();
        tv[0] = '1;
        tv[2] = 32'd1;
        run_frame();

        // R6 R11: hold stability and restart during a hold
        req = "R6_R11";
        mixed_tables();
        pulse_start();
        wait_sel();
        chk(sel_vld && sel_class == 2'd0 && sel_slot == 5'd3, "R2 first iso", {sel_class, sel_slot}, 3);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(sel_vld && sel_class == 2'd0 && sel_slot == 5'd3, "R6 held", {sel_class, sel_slot}, 3);
        end
        man_ack = 1'b1;
        repeat (2) @(negedge clk);
        wait_sel();
        chk(sel_vld && sel_class == 2'd1 && sel_slot == 5'd0, "R2 int after iso", {sel_class, sel_slot}, 32);
        pulse_start();
        chk(!sel_vld, "R11 selection dropped", sel_vld, 0);
        wait_sel();
        chk(sel_vld && sel_class == 2'd0 && sel_slot == 5'd3, "R11 restart iso", {sel_class, sel_slot}, 3);
        model_push();
        ack_en = 1'b1;
        wait_idle();
        ack_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule